// File: doc/BRIEF.md
# Serial Memory Sequential Read Master

This block is an SPI master that pulls a run of bytes out of a standard serial EEPROM or flash. A one-cycle start pulse captures a start address, an address width and a byte count. The block then drops the chip select and shifts out the read opcode 0x03, followed by one, two or three address bytes. After that it keeps clocking, and the memory returns the contents of consecutive locations without being addressed again.

Each received byte is offered on a valid/ready stream. When the consumer is not ready, SCLK is parked low between bytes, so no data is lost and the memory does not need to be addressed again. After the last requested byte has been accepted, the chip select is released and a one-cycle done pulse is raised. A typical use is at boot time, where a loader streams a stored image out of external serial memory.

Top module: `spi_mem_reader`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, m_valid_o is 0, done_o is 0 and busy_o is 0.
- R2: The first byte shifted out on mosi_o after cs_no falls is the opcode 0x03. The bus runs in SPI mode 0: SCLK idles low, mosi_o changes only while SCLK is low, bits are sampled on the SCLK rising edge, and the most significant bit goes first.
- R3: With addr_mode_i = 0 (8-bit addressing), exactly one address byte, addr_i[7:0], follows the opcode.
- R4: With addr_mode_i = 1 (16-bit addressing), two address bytes follow the opcode, addr_i[15:8] first and then addr_i[7:0].
- R5: With addr_mode_i = 2 or 3 (24-bit addressing), three address bytes follow the opcode, most significant byte first.
- R6: After the address, exactly len_i data bytes are clocked in from miso_i. Data byte k is presented on m_data_o, and it is the memory content at the sent address plus k. mosi_o is 0 during the data bytes.
- R7: cs_no stays low without a break from before the first SCLK rising edge until after the last one. A transaction has exactly 8*(1+address bytes+len_i) SCLK rising edges.
- R8: While m_valid_o is 1 and m_ready_i is 0, sclk_o stays low and m_valid_o and m_data_o stay unchanged.
- R9: done_o pulses for one cycle on the cycle cs_no returns high after the last handshake. A start with len_i = 0 gives a done pulse with no chip select and no SCLK.
- R10: A start_i pulse while busy_o is 1 is ignored. The running transaction completes with its own parameters, and no further transaction follows.
- R11: Each SCLK high phase lasts exactly CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 24 | Start address of the read |
| addr_mode_i | input | 2 | Address width: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 24-bit |
| len_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | A transaction is in progress |
| m_data_o | output | 8 | Received byte |
| m_valid_o | output | 1 | m_data_o holds a byte |
| m_ready_i | input | 1 | Consumer accepts the byte |
| done_o | output | 1 | One-cycle pulse when the transaction has ended |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Memory chip select, active low |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory |

## Verification
The assertions place no constraint on m_ready_i. It may drop or rise on any cycle, and they check that stalls hold SCLK and the output byte steady whatever that input does. They do assume that miso_i is driven by a memory following mode 0 timing, and that start_i is a single-cycle pulse. The bench memory model changes miso_i only after an SCLK falling edge. The consumer toggles ready from a pseudo-random sequence, and one scenario fires a second start pulse in the middle of a transfer.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] RD_OPCODE = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_HOLD
  } rd_state_e;

  function automatic logic [1:0] addr_bytes(input logic [1:0] mode);
    case (mode)
      2'd0:    addr_bytes = 2'd1;
      2'd1:    addr_bytes = 2'd2;
      default: addr_bytes = 2'd3;
    endcase
  endfunction

  function automatic logic [23:0] addr_align(input logic [23:0] a, input logic [1:0] mode);
    case (mode)
      2'd0:    addr_align = {a[7:0], 16'h0};
      2'd1:    addr_align = {a[15:0], 8'h0};
      default: addr_align = a;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned HC_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(CLK_DIV - 1);

  logic [HC_W-1:0] half_cnt;
  logic [2:0]      bit_cnt;
  logic [7:0]      sh_tx, sh_rx;
  logic            sclk_q, busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_cnt <= '0;
      bit_cnt  <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      sclk_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q   <= 1'b1;
          sh_tx    <= tx_i;
          bit_cnt  <= '0;
          half_cnt <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (half_cnt == HC_LAST) begin
        half_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          sh_rx  <= {sh_rx[6:0], miso_i};
        end else begin
          sclk_q  <= 1'b0;
          sh_tx   <= {sh_tx[6:0], 1'b0};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  assign rx_o   = sh_rx;
  assign done_o = done_q;
  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = sh_tx[7];

  // R2: SCLK only runs inside a byte
  a_r2_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  // R2: MOSI moves only while SCLK is low
  a_r2_mosi_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [1:0]       addr_mode_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [7:0]       m_data_o,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic             done_o,
  output logic             cs_no,
  output logic             go_o,
  output logic [7:0]       tx_o,
  input  logic             eng_done_i,
  input  logic [7:0]       eng_rx_i
);
  import spi_rd_pkg::*;

  rd_state_e        state;
  logic [CNT_W-1:0] remaining;
  logic [23:0]      addr_sh;
  logic [1:0]       addr_left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      remaining <= '0;
      addr_sh   <= '0;
      addr_left <= '0;
      m_data_o  <= '0;
      m_valid_o <= 1'b0;
      done_o    <= 1'b0;
      cs_no     <= 1'b1;
      go_o      <= 1'b0;
      tx_o      <= '0;
    end else begin
      go_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          if (len_i == '0) begin
            done_o <= 1'b1;
          end else begin
            cs_no     <= 1'b0;
            go_o      <= 1'b1;
            tx_o      <= RD_OPCODE;
            remaining <= len_i;
            addr_sh   <= addr_align(addr_i, addr_mode_i);
            addr_left <= addr_bytes(addr_mode_i);
            state     <= ST_HDR;
          end
        end
        ST_HDR: if (eng_done_i) begin
          go_o <= 1'b1;
          if (addr_left != 2'd0) begin
            tx_o      <= addr_sh[23:16];
            addr_sh   <= {addr_sh[15:0], 8'h0};
            addr_left <= addr_left - 2'd1;
          end else begin
            tx_o  <= 8'h00;
            state <= ST_DATA;
          end
        end
        ST_DATA: if (eng_done_i) begin
          m_data_o  <= eng_rx_i;
          m_valid_o <= 1'b1;
          state     <= ST_HOLD;
        end
        ST_HOLD: if (m_ready_i) begin
          m_valid_o <= 1'b0;
          remaining <= remaining - 1'b1;
          if (remaining == CNT_W'(1)) begin
            cs_no  <= 1'b1;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            go_o  <= 1'b1;
            tx_o  <= 8'h00;
            state <= ST_DATA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));
  a_r9_done_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(state == ST_HOLD && m_ready_i)) |=> busy_o);
  a_r8_no_go_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> !go_o);
endmodule

// File: rtl/spi_mem_reader.sv
module spi_mem_reader #(
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [1:0]       addr_mode_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [7:0]       m_data_o,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic       go, eng_done, eng_busy;
  logic [7:0] tx, rx;

  spi_rd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_i, .addr_mode_i, .len_i,
    .busy_o, .m_data_o, .m_valid_o, .m_ready_i, .done_o, .cs_no,
    .go_o(go), .tx_o(tx), .eng_done_i(eng_done), .eng_rx_i(rx)
  );

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk_i, .rst_ni, .go_i(go), .tx_i(tx), .rx_o(rx), .done_o(eng_done),
    .busy_o(eng_busy), .sclk_o, .mosi_o, .miso_i
  );

  // R7: no clock edge without the chip selected
  a_r7_cs_frames_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!sclk_o && !eng_busy));
  // R8: serial clock parked while a byte waits
  a_r8_sclk_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> (!sclk_o && !eng_busy));
endmodule

// File: tb/spi_mem_reader_tb.sv
module spi_mem_reader_tb;
  localparam int CLK_DIV = 2;
  localparam int CNT_W   = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, m_ready = 0, miso = 0;
  logic [23:0] addr = 0;
  logic [1:0]  amode = 0;
  logic [CNT_W-1:0] len = 0;
  logic busy, m_valid, done, sclk, cs_n, mosi;
  logic [7:0] m_data;

  always #2.5 clk = ~clk;

  spi_mem_reader #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .addr_mode_i(amode), .len_i(len), .busy_o(busy), .m_data_o(m_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .done_o(done), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit timed_out = 0;

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    mem_f = a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  // memory model and consumer state
  int         m_abytes = 1;
  int         bit_n = 0, cap_n = 0, rises = 0;
  logic [7:0] sh = 0;
  logic [7:0] cap [0:63];
  logic [23:0] m_addr = 0;
  logic       sclk_prev = 0;
  int         hi_run = 0, hi_min = 1000, hi_max = 0;
  logic [7:0] got [0:63];
  int         got_n = 0, done_n = 0, cs_after = 0, stall_bad = 0, mosi_bad = 0;
  bit         stall_en = 0, done_seen = 0, prev_stall = 0;
  logic [7:0] prev_data = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    cyc++;
    // memory side
    if (cs_n) begin
      bit_n = 0;
    end else begin
      if (sclk && !sclk_prev) begin
        sh = {sh[6:0], mosi};
        bit_n++;
        rises++;
        if (bit_n % 8 == 0) begin
          if (cap_n < 64) cap[cap_n] = sh;
          cap_n++;
          if (cap_n == 1 + m_abytes) begin
            m_addr = 0;
            for (int i = 1; i <= m_abytes; i++) m_addr = {m_addr[15:0], cap[i]};
          end
        end
      end
      if (!sclk && sclk_prev && bit_n >= 8 * (1 + m_abytes)) begin
        miso = mem_f(m_addr + 24'((bit_n - 8 * (1 + m_abytes)) / 8))[7 - (bit_n % 8)];
      end
      // data bytes must be zero on MOSI while SCLK high
      if (sclk && bit_n > 8 * (1 + m_abytes) && mosi) mosi_bad++;
    end
    if (sclk) hi_run++;
    else if (sclk_prev) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    sclk_prev = sclk;
    // consumer side
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (prev_stall && m_valid && (sclk || m_data != prev_data)) stall_bad++;
    m_ready = stall_en ? lfsr[0] : 1'b1;
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
    if (m_valid && m_ready) begin
      if (got_n < 64) got[got_n] = m_data;
      got_n++;
    end
    if (done) begin
      done_n++;
      done_seen = 1;
      if (!cs_n) stall_bad++;
    end else if (done_seen && !cs_n) cs_after++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    cap_n = 0; rises = 0; got_n = 0; done_n = 0; cs_after = 0;
    stall_bad = 0; mosi_bad = 0; done_seen = 0;
    hi_min = 1000; hi_max = 0;
  endtask

  task automatic pulse_start(input logic [23:0] a, input logic [1:0] md, input int n);
    @(negedge clk);
    addr = a; amode = md; len = CNT_W'(n); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done_seen && !timed_out) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 cs/sclk", {30'd0, cs_n, sclk}, 2);
    chk(m_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R1 outputs",
        {29'd0, m_valid, done, busy}, 0);
  endtask

  task automatic t_read(input logic [23:0] a, input logic [1:0] md, input int n,
                        input bit stall, input bit inject, input string rq);
    int ab;
    logic [23:0] ea;
    ab = (md == 0) ? 1 : (md == 1) ? 2 : 3;
    ea = (md == 0) ? {16'd0, a[7:0]} : (md == 1) ? {8'd0, a[15:0]} : a;
    clr();
    m_abytes = ab;
    stall_en = stall;
    pulse_start(a, md, n);
    if (inject) begin
      repeat (30) @(negedge clk);
      chk(busy === 1'b1, "R10 busy mid-run", busy, 1);
      pulse_start(24'h00F00D, 2'd2, 9);
    end
    wait_done();
    chk(cap[0] == 8'h03, "R2 opcode", cap[0], 3);
    chk(m_addr == ea, {rq, " address bytes"}, m_addr, ea);
    chk(rises == 8 * (1 + ab + n), "R7 edge count", rises, 8 * (1 + ab + n));
    chk(got_n == n, "R6 byte count", got_n, n);
    for (int k = 0; k < n && k < 64; k++)
      chk(got[k] == mem_f(ea + 24'(k)), "R6 data", got[k], mem_f(ea + 24'(k)));
    chk(mosi_bad == 0, "R6 mosi low in data", mosi_bad, 0);
    chk(done_n == 1 && stall_bad == 0, "R9/R8 done and stall",
        done_n * 100 + stall_bad, 100);
    chk(cs_after == 0, "R10 no extra transaction", cs_after, 0);
    chk(hi_min == CLK_DIV && hi_max == CLK_DIV, "R11 high phase", hi_max, CLK_DIV);
    stall_en = 0;
  endtask

  task automatic t_len0();
    clr();
    pulse_start(24'h123456, 2'd1, 0);
    wait_done();
    chk(done_n == 1, "R9 zero length done", done_n, 1);
    chk(rises == 0 && cap_n == 0, "R9 zero length no bus", rises, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_read(24'h3C4D5E, 2'd0, 4, 0, 0, "R3");
    t_read(24'h00ABCD, 2'd1, 6, 0, 0, "R4");
    t_read(24'h12FFFE, 2'd2, 5, 1, 0, "R5");
    t_read(24'hFEDCBA, 2'd3, 3, 0, 0, "R5");
    t_read(24'h000010, 2'd1, 20, 1, 0, "R8");
    t_read(24'h0A0B0C, 2'd2, 4, 0, 1, "R10");
    t_len0();
    t_read(24'h0000FF, 2'd0, 1, 1, 0, "R3");
    if (timed_out) n_fail++;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    timed_out = 1;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule